// File: doc/BRIEF.md
# Pipeline hazard control unit

This unit steers the pipeline registers of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Every cycle it looks at the register fields and the instruction class held in each stage. From these it decides which pipeline registers hold their contents (stall) and which emit a no-op (bubble). It also tells the decode stage where each of its two source operands should come from. The datapath, register file, ALU and memories sit outside it. The unit is purely combinational. The clock and reset inputs serve only the embedded property checks.

The unit resolves three kinds of hazard. A data hazard arises when decode needs a register that an older instruction has not yet produced. A return hazard arises because the return address is only known once the return leaves the memory stage. A mispredicted conditional branch hazard arises because branches are predicted taken and resolve in execute. The compile-time parameter `FORWARD_EN` picks between two variants. With bypassing, only a load followed at once by a consumer costs a cycle. Without it, decode waits until the producer has written back.

Top module: `hzd_unit`

## Requirements
- R1: With no hazard present (all register fields 0xF, no return, no branch), every stall and bubble output is 0 and both forward selects are 0. The memory and writeback registers are never stalled or bubbled.
- R2: With forwarding on, each source operand that is not 0xF takes the first match in this priority order: execute result (code 1), memory-stage loaded value (2), memory-stage ALU result (3), writeback loaded value (4), writeback ALU result (5). Otherwise it takes the register file (0).
- R3: With forwarding on, a decode source equal to the load destination of the instruction in execute stalls fetch and decode and bubbles execute in the same cycle, for exactly one cycle. Decode is not bubbled.
- R4: With forwarding off, a decode source equal to any destination in execute, memory or writeback stalls fetch and decode and bubbles execute. Both forward selects stay 0. Back-to-back dependent instructions cost 3 stall cycles, and one independent instruction in between leaves 2.
- R5: A return in decode, execute or memory stalls fetch and bubbles decode, which gives exactly 3 decode bubbles per return.
- R6: A conditional branch in execute whose taken flag is 0 (predicted taken, actually not) bubbles both decode and execute for one cycle, with no stalls, so that no wrong-path instruction retires. A correctly predicted branch costs nothing.
- R7: A mispredict outranks a return or a data stall in the same cycle: only the decode and execute bubbles are raised.
- R8: A load-use stall outranks a return in decode: decode is stalled, not bubbled.
- R9: Register index 0xF never creates a dependence or a forward.
- R10: A pop (which writes the stack pointer, register 4, from the ALU and a data register from memory) followed by a stack-pointer reader costs no cycle with forwarding and 3 stall cycles without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded checks |
| rst_n | input | 1 | Active-low reset for the embedded checks |
| d_src_a | input | REG_W | First source register of the decode instruction |
| d_src_b | input | REG_W | Second source register of the decode instruction |
| d_is_ret | input | 1 | Decode holds a return |
| e_dst_e | input | REG_W | ALU destination of the execute instruction |
| e_dst_m | input | REG_W | Load destination of the execute instruction |
| e_is_ret | input | 1 | Execute holds a return |
| e_is_cbr | input | 1 | Execute holds a conditional branch |
| e_taken | input | 1 | Branch in execute resolved taken |
| m_dst_e | input | REG_W | ALU destination in memory stage |
| m_dst_m | input | REG_W | Load destination in memory stage |
| m_is_ret | input | 1 | Memory stage holds a return |
| w_dst_e | input | REG_W | ALU destination in writeback |
| w_dst_m | input | REG_W | Load destination in writeback |
| f_stall | output | 1 | Hold the fetch register |
| d_stall | output | 1 | Hold the decode register |
| d_bubble | output | 1 | Load a no-op into decode |
| e_stall | output | 1 | Hold the execute register |
| e_bubble | output | 1 | Load a no-op into execute |
| m_stall | output | 1 | Hold the memory register |
| m_bubble | output | 1 | Load a no-op into memory |
| w_stall | output | 1 | Hold the writeback register |
| w_bubble | output | 1 | Load a no-op into writeback |
| fwd_a | output | 3 | Source select for operand A |
| fwd_b | output | 3 | Source select for operand B |

## Verification
The bench builds two copies side by side: one with `FORWARD_EN` = 1 and one with `FORWARD_EN` = 0, both with 4-bit register indices and 0xF as the empty index. A stub pipeline driven by the selected copy runs short programs. The bench counts stall, bubble and squash cycles, so the one-cycle load-use penalty and the three-cycle writeback wait are both observed with the same instruction sequences. Direct input vectors reach the forward priority chain and the cross-hazard priority cases, which the stub programs would rarely line up.

// File: rtl/hzd_pkg.sv
`timescale 1ns/1ps
package hzd_pkg;

   // operand source codes seen by the decode bypass mux
   localparam int FWD_W = 3;
   typedef enum logic [FWD_W-1:0] {
      FWD_RF     = 3'd0,
      FWD_E_ALU  = 3'd1,
      FWD_M_LOAD = 3'd2,
      FWD_M_ALU  = 3'd3,
      FWD_W_LOAD = 3'd4,
      FWD_W_ALU  = 3'd5
   } fwd_sel_e;

   // producer slots in priority order (youngest first)
   localparam int NSLOT     = 6;
   localparam int SL_E_ALU  = 0;
   localparam int SL_E_LOAD = 1;
   localparam int SL_M_LOAD = 2;
   localparam int SL_M_ALU  = 3;
   localparam int SL_W_LOAD = 4;
   localparam int SL_W_ALU  = 5;

   // pipeline register indices
   localparam int NSTAGE = 5;
   localparam int ST_F = 0;
   localparam int ST_D = 1;
   localparam int ST_E = 2;
   localparam int ST_M = 3;
   localparam int ST_W = 4;

   typedef struct packed {
      logic stall;
      logic bubble;
   } stage_ctl_t;

endpackage

// File: rtl/hzd_reg_match.sv
`timescale 1ns/1ps
module hzd_reg_match #(
   parameter int               REG_W = 4,
   parameter logic [REG_W-1:0] NOREG = '1
) (
   input  logic [REG_W-1:0] src,
   input  logic [REG_W-1:0] dst,
   output logic             hit
);
   // the empty index never pairs with anything
   assign hit = (src != NOREG) && (src == dst);
endmodule

// File: rtl/hzd_fwd_pick.sv
`timescale 1ns/1ps
module hzd_fwd_pick
   import hzd_pkg::*;
#(
   parameter int               REG_W      = 4,
   parameter logic [REG_W-1:0] NOREG      = '1,
   parameter bit               FORWARD_EN = 1'b1
) (
   input  logic [REG_W-1:0]            src,
   input  logic [NSLOT-1:0][REG_W-1:0] dsts,
   output fwd_sel_e                    sel,
   output logic                        need_hold
);
   logic [NSLOT-1:0] hits;

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      hzd_reg_match #(.REG_W(REG_W), .NOREG(NOREG)) u_match (
         .src (src),
         .dst (dsts[s]),
         .hit (hits[s])
      );
   end

   if (FORWARD_EN) begin : g_bypass
      // a value still in the memory access cannot be bypassed yet
      assign need_hold = hits[SL_E_LOAD];
      always_comb begin
         if      (hits[SL_E_ALU])  sel = FWD_E_ALU;
         else if (hits[SL_M_LOAD]) sel = FWD_M_LOAD;
         else if (hits[SL_M_ALU])  sel = FWD_M_ALU;
         else if (hits[SL_W_LOAD]) sel = FWD_W_LOAD;
         else if (hits[SL_W_ALU])  sel = FWD_W_ALU;
         else                      sel = FWD_RF;
      end
   end else begin : g_wait_wb
      // every in-flight producer must leave writeback first
      assign need_hold = |hits;
      assign sel       = FWD_RF;
   end
endmodule

// File: rtl/hzd_ctrl_arb.sv
`timescale 1ns/1ps
module hzd_ctrl_arb
   import hzd_pkg::*;
(
   input  logic                    data_hold,
   input  logic                    ret_pend,
   input  logic                    mispredict,
   output stage_ctl_t [NSTAGE-1:0] ctl
);
   always_comb begin
      for (int s = 0; s < NSTAGE; s++) ctl[s] = '0;
      if (mispredict) begin
         // younger slots are wrong path: squash, never hold
         ctl[ST_D].bubble = 1'b1;
         ctl[ST_E].bubble = 1'b1;
      end else if (data_hold) begin
         ctl[ST_F].stall  = 1'b1;
         ctl[ST_D].stall  = 1'b1;
         ctl[ST_E].bubble = 1'b1;
      end else if (ret_pend) begin
         ctl[ST_F].stall  = 1'b1;
         ctl[ST_D].bubble = 1'b1;
      end
   end
endmodule

// File: rtl/hzd_unit.sv
`timescale 1ns/1ps
module hzd_unit
   import hzd_pkg::*;
#(
   parameter int               REG_W      = 4,
   parameter logic [REG_W-1:0] NOREG      = '1,
   parameter bit               FORWARD_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] d_src_a,
   input  logic [REG_W-1:0] d_src_b,
   input  logic             d_is_ret,
   input  logic [REG_W-1:0] e_dst_e,
   input  logic [REG_W-1:0] e_dst_m,
   input  logic             e_is_ret,
   input  logic             e_is_cbr,
   input  logic             e_taken,
   input  logic [REG_W-1:0] m_dst_e,
   input  logic [REG_W-1:0] m_dst_m,
   input  logic             m_is_ret,
   input  logic [REG_W-1:0] w_dst_e,
   input  logic [REG_W-1:0] w_dst_m,
   output logic             f_stall,
   output logic             d_stall,
   output logic             d_bubble,
   output logic             e_stall,
   output logic             e_bubble,
   output logic             m_stall,
   output logic             m_bubble,
   output logic             w_stall,
   output logic             w_bubble,
   output logic [FWD_W-1:0] fwd_a,
   output logic [FWD_W-1:0] fwd_b
);
   localparam int NOPND = 2;

   initial begin : p_param_chk
      assert (REG_W >= 2 && REG_W <= 8)
         else $error("hzd_unit: REG_W out of range");
   end

   logic [NSLOT-1:0][REG_W-1:0] dsts;
   logic [NOPND-1:0][REG_W-1:0] srcs;
   fwd_sel_e   [NOPND-1:0]      sels;
   logic       [NOPND-1:0]      holds;
   stage_ctl_t [NSTAGE-1:0]     ctl;
   logic ret_any, mispredict, data_hold;

   always_comb begin
      dsts[SL_E_ALU]  = e_dst_e;
      dsts[SL_E_LOAD] = e_dst_m;
      dsts[SL_M_LOAD] = m_dst_m;
      dsts[SL_M_ALU]  = m_dst_e;
      dsts[SL_W_LOAD] = w_dst_m;
      dsts[SL_W_ALU]  = w_dst_e;
   end
   assign srcs = {d_src_b, d_src_a};

   for (genvar o = 0; o < NOPND; o++) begin : g_opnd
      hzd_fwd_pick #(.REG_W(REG_W), .NOREG(NOREG), .FORWARD_EN(FORWARD_EN)) u_pick (
         .src       (srcs[o]),
         .dsts      (dsts),
         .sel       (sels[o]),
         .need_hold (holds[o])
      );
   end

   assign ret_any    = d_is_ret | e_is_ret | m_is_ret;
   assign mispredict = e_is_cbr & ~e_taken;
   assign data_hold  = |holds;

   hzd_ctrl_arb u_arb (
      .data_hold  (data_hold),
      .ret_pend   (ret_any),
      .mispredict (mispredict),
      .ctl        (ctl)
   );

   assign f_stall  = ctl[ST_F].stall;
   assign d_stall  = ctl[ST_D].stall;
   assign d_bubble = ctl[ST_D].bubble;
   assign e_stall  = ctl[ST_E].stall;
   assign e_bubble = ctl[ST_E].bubble;
   assign m_stall  = ctl[ST_M].stall;
   assign m_bubble = ctl[ST_M].bubble;
   assign w_stall  = ctl[ST_W].stall;
   assign w_bubble = ctl[ST_W].bubble;
   assign fwd_a    = sels[0];
   assign fwd_b    = sels[1];

   // ---------------- embedded checks ----------------
   a_r3_hold_shape: assert property (@(posedge clk) disable iff (!rst_n)
      d_stall |-> (f_stall && e_bubble && !d_bubble));

   a_r5_ret_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_any && !e_is_cbr && !d_stall) |-> (f_stall && d_bubble));

   a_r6_squash: assert property (@(posedge clk) disable iff (!rst_n)
      mispredict |-> (d_bubble && e_bubble && !f_stall && !d_stall));

   a_r9_noreg_a: assert property (@(posedge clk) disable iff (!rst_n)
      (d_src_a == NOREG) |-> (fwd_a == 3'd0));

   a_r9_noreg_b: assert property (@(posedge clk) disable iff (!rst_n)
      (d_src_b == NOREG && e_dst_m == NOREG && !ret_any && !mispredict
       && (d_src_a == NOREG)) |-> (!f_stall && !d_stall && fwd_b == 3'd0));

   if (FORWARD_EN) begin : g_chk_fwd
      a_r2_exec_first: assert property (@(posedge clk) disable iff (!rst_n)
         (d_src_a != NOREG && d_src_a == e_dst_e) |-> (fwd_a == 3'd1));
   end else begin : g_chk_nofwd
      a_r4_wait_wb: assert property (@(posedge clk) disable iff (!rst_n)
         (d_src_a != NOREG && d_src_a == w_dst_e && !mispredict) |-> d_stall);
   end
endmodule

// File: tb/test_hzd_unit.sv
`timescale 1ns/1ps
module test_hzd_unit;
   localparam logic [3:0] NR = 4'hF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   int n_chk = 0;
   int n_err = 0;

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   typedef struct packed {
      logic [7:0] idx;
      logic [3:0] sa, sb, de, dm;
      logic ret, cbr, tkn, rl, junk;
   } ins_t;

   function automatic ins_t nop_i();
      ins_t r;
      r = '0; r.sa = NR; r.sb = NR; r.de = NR; r.dm = NR;
      return r;
   endfunction

   function automatic ins_t mk(input int idx, input logic [3:0] sa, sb, de, dm,
                               input logic ret, cbr, tkn);
      ins_t r;
      r.idx = idx[7:0]; r.sa = sa; r.sb = sb; r.de = de; r.dm = dm;
      r.ret = ret; r.cbr = cbr; r.tkn = tkn; r.rl = 1'b1; r.junk = 1'b0;
      return r;
   endfunction

   ins_t prog [16];
   int   plen = 0;
   bit   run_en = 1'b0;
   bit   use_fwd = 1'b1;
   bit   dir_mode = 1'b1;

   // direct-drive vector
   logic [3:0] v_sa = NR, v_sb = NR, v_ede = NR, v_edm = NR, v_mde = NR, v_mdm = NR, v_wde = NR, v_wdm = NR;
   logic v_dret = 1'b0, v_eret = 1'b0, v_ecbr = 1'b0, v_etkn = 1'b0, v_mret = 1'b0;

   // stub pipeline state
   ins_t sD, sE, sM, sW, fe;
   int pc;
   bit wrong;
   int cnt_fst, cnt_dbub, cnt_ebub, cnt_sq, retired, junk_ret;

   // DUT inputs
   logic [3:0] t_sa, t_sb, t_ede, t_edm, t_mde, t_mdm, t_wde, t_wdm;
   logic t_dret, t_eret, t_ecbr, t_etkn, t_mret;

   always_comb begin
      if (dir_mode) begin
         t_sa = v_sa; t_sb = v_sb; t_dret = v_dret;
         t_ede = v_ede; t_edm = v_edm; t_eret = v_eret; t_ecbr = v_ecbr; t_etkn = v_etkn;
         t_mde = v_mde; t_mdm = v_mdm; t_mret = v_mret; t_wde = v_wde; t_wdm = v_wdm;
      end else begin
         t_sa = sD.sa; t_sb = sD.sb; t_dret = sD.ret;
         t_ede = sE.de; t_edm = sE.dm; t_eret = sE.ret; t_ecbr = sE.cbr; t_etkn = sE.tkn;
         t_mde = sM.de; t_mdm = sM.dm; t_mret = sM.ret; t_wde = sW.de; t_wdm = sW.dm;
      end
   end

   logic a_fs, a_ds, a_db, a_es, a_eb, a_ms, a_mb, a_ws, a_wb;
   logic b_fs, b_ds, b_db, b_es, b_eb, b_ms, b_mb, b_ws, b_wb;
   logic [2:0] a_fa, a_fb, b_fa, b_fb;

   hzd_unit #(.REG_W(4), .NOREG(4'hF), .FORWARD_EN(1'b1)) i_hzd_unit (
      .clk(clk), .rst_n(rst_n), .d_src_a(t_sa), .d_src_b(t_sb), .d_is_ret(t_dret),
      .e_dst_e(t_ede), .e_dst_m(t_edm), .e_is_ret(t_eret), .e_is_cbr(t_ecbr), .e_taken(t_etkn),
      .m_dst_e(t_mde), .m_dst_m(t_mdm), .m_is_ret(t_mret), .w_dst_e(t_wde), .w_dst_m(t_wdm),
      .f_stall(a_fs), .d_stall(a_ds), .d_bubble(a_db), .e_stall(a_es), .e_bubble(a_eb),
      .m_stall(a_ms), .m_bubble(a_mb), .w_stall(a_ws), .w_bubble(a_wb), .fwd_a(a_fa), .fwd_b(a_fb));

   hzd_unit #(.REG_W(4), .NOREG(4'hF), .FORWARD_EN(1'b0)) i_hzd_unit_nofwd (
      .clk(clk), .rst_n(rst_n), .d_src_a(t_sa), .d_src_b(t_sb), .d_is_ret(t_dret),
      .e_dst_e(t_ede), .e_dst_m(t_edm), .e_is_ret(t_eret), .e_is_cbr(t_ecbr), .e_taken(t_etkn),
      .m_dst_e(t_mde), .m_dst_m(t_mdm), .m_is_ret(t_mret), .w_dst_e(t_wde), .w_dst_m(t_wdm),
      .f_stall(b_fs), .d_stall(b_ds), .d_bubble(b_db), .e_stall(b_es), .e_bubble(b_eb),
      .m_stall(b_ms), .m_bubble(b_mb), .w_stall(b_ws), .w_bubble(b_wb), .fwd_a(b_fa), .fwd_b(b_fb));

   logic c_fs, c_ds, c_db, c_es, c_eb, c_ms, c_mb, c_ws, c_wb;
   logic [2:0] c_fa, c_fb;
   logic [14:0] obs;
   always_comb begin
      if (use_fwd) begin
         {c_fs, c_ds, c_db, c_es, c_eb, c_ms, c_mb, c_ws, c_wb} = {a_fs, a_ds, a_db, a_es, a_eb, a_ms, a_mb, a_ws, a_wb};
         c_fa = a_fa; c_fb = a_fb;
      end else begin
         {c_fs, c_ds, c_db, c_es, c_eb, c_ms, c_mb, c_ws, c_wb} = {b_fs, b_ds, b_db, b_es, b_eb, b_ms, b_mb, b_ws, b_wb};
         c_fa = b_fa; c_fb = b_fb;
      end
   end
   assign obs = {c_fs, c_ds, c_db, c_es, c_eb, c_ms, c_mb, c_ws, c_wb, c_fa, c_fb};

   // fetch: wrong path yields junk, past the end yields no-ops
   always_comb begin
      if (wrong) begin
         fe = nop_i(); fe.junk = 1'b1;
      end else if (pc < plen) begin
         fe = prog[pc[3:0]];
      end else begin
         fe = nop_i();
      end
   end

   always_ff @(posedge clk) begin
      if (!run_en) begin
         sD <= nop_i(); sE <= nop_i(); sM <= nop_i(); sW <= nop_i();
         pc <= 0; wrong <= 1'b0;
         cnt_fst <= 0; cnt_dbub <= 0; cnt_ebub <= 0; cnt_sq <= 0; retired <= 0; junk_ret <= 0;
      end else begin
         cnt_fst  <= cnt_fst  + (c_fs ? 1 : 0);
         cnt_dbub <= cnt_dbub + (c_db ? 1 : 0);
         cnt_ebub <= cnt_ebub + (c_eb ? 1 : 0);
         cnt_sq   <= cnt_sq   + ((c_db && c_eb) ? 1 : 0);
         retired  <= retired  + (sM.rl ? 1 : 0);
         junk_ret <= junk_ret + (sM.junk ? 1 : 0);
         sW <= c_wb ? nop_i() : (c_ws ? sW : sM);
         sM <= c_mb ? nop_i() : (c_ms ? sM : sE);
         sE <= c_eb ? nop_i() : (c_es ? sE : sD);
         sD <= c_ds ? sD : (c_db ? nop_i() : fe);
         if (sE.cbr && !sE.tkn) begin
            pc <= int'(sE.idx) + 1;
            wrong <= 1'b0;
         end else if (!c_fs && !wrong && pc < plen) begin
            pc <= pc + 1;
            if (fe.cbr && !fe.tkn) wrong <= 1'b1;
         end
      end
   end

   // scoreboard for direct vectors
   string       req_q[$];
   logic [14:0] exp_q[$];

   always @(negedge clk) begin
      if (exp_q.size() != 0) begin
         string r;
         logic [14:0] e;
         r = req_q.pop_front();
         e = exp_q.pop_front();
         chk(r, "controls", int'(obs), int'(e));
      end
   end

   function automatic logic [14:0] ex(input logic fs, ds, db, eb, input logic [2:0] fa, fb);
      return {fs, ds, db, 1'b0, eb, 4'b0000, fa, fb};
   endfunction

   task automatic idle_v();
      v_sa = NR; v_sb = NR; v_ede = NR; v_edm = NR; v_mde = NR; v_mdm = NR; v_wde = NR; v_wdm = NR;
      v_dret = 1'b0; v_eret = 1'b0; v_ecbr = 1'b0; v_etkn = 1'b0; v_mret = 1'b0;
   endtask

   // driver: vector fields are set by the caller after idle_v, then pushed
   task automatic push(input bit fwd, input logic [14:0] e, input string req);
      use_fwd = fwd;
      req_q.push_back(req);
      exp_q.push_back(e);
      @(posedge clk);
      #1;
      idle_v();
   endtask

   task automatic run_prog(input bit fwd, input int n, input int e_fst, e_dbub, e_ebub, e_sq,
                           input string req);
      use_fwd = fwd;
      dir_mode = 1'b0;
      plen = n;
      run_en = 1'b0;
      repeat (2) @(posedge clk);
      #1 run_en = 1'b1;
      for (int k = 0; k < 200 && retired < n; k++) @(posedge clk);
      repeat (3) @(posedge clk);
      #1;
      chk(req, "retired", retired, n);
      chk(req, "fetch stall cycles", cnt_fst, e_fst);
      chk(req, "decode bubble cycles", cnt_dbub, e_dbub);
      chk(req, "execute bubble cycles", cnt_ebub, e_ebub);
      chk(req, "squash cycles", cnt_sq, e_sq);
      chk(req, "wrong-path retired", junk_ret, 0);
      run_en = 1'b0;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin : stimulus
      idle_v();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 idle state, both variants
      push(1'b1, ex(0,0,0,0,3'd0,3'd0), "R1");
      push(1'b0, ex(0,0,0,0,3'd0,3'd0), "R1");
      // R2 forwarding priority
      v_sa = 4'd3; v_ede = 4'd3; v_mdm = 4'd3;  push(1'b1, ex(0,0,0,0,3'd1,3'd0), "R2");
      v_sa = 4'd3; v_mdm = 4'd3; v_mde = 4'd3;  push(1'b1, ex(0,0,0,0,3'd2,3'd0), "R2");
      v_sb = 4'd3; v_mde = 4'd3; v_wdm = 4'd3;  push(1'b1, ex(0,0,0,0,3'd0,3'd3), "R2");
      v_sb = 4'd3; v_wdm = 4'd3; v_wde = 4'd3;  push(1'b1, ex(0,0,0,0,3'd0,3'd4), "R2");
      v_sa = 4'd3; v_sb = 4'd5; v_wde = 4'd3;   push(1'b1, ex(0,0,0,0,3'd5,3'd0), "R2");
      // R3 load-use shape
      v_sb = 4'd3; v_edm = 4'd3;                push(1'b1, ex(1,1,0,1,3'd0,3'd0), "R3");
      // R9 empty index with every field empty, and matching empty fields
      v_sa = NR; v_ede = NR; v_wde = NR;        push(1'b0, ex(0,0,0,0,3'd0,3'd0), "R9");
      // R8 load-use beats return in decode
      v_dret = 1'b1; v_sb = 4'd4; v_edm = 4'd4; push(1'b1, ex(1,1,0,1,3'd0,3'd0), "R8");
      // R7 mispredict beats return and data holds
      v_dret = 1'b1; v_ecbr = 1'b1;             push(1'b1, ex(0,0,1,1,3'd0,3'd0), "R7");
      v_sa = 4'd3; v_mde = 4'd3; v_ecbr = 1'b1; push(1'b0, ex(0,0,1,1,3'd0,3'd0), "R7");
      v_sa = 4'd3; v_edm = 4'd3; v_ecbr = 1'b1; push(1'b1, ex(0,0,1,1,3'd0,3'd0), "R7");
      // R4 writeback wait, no bypass code
      v_sa = 4'd3; v_wde = 4'd3;                push(1'b0, ex(1,1,0,1,3'd0,3'd0), "R4");
      // R5 return further down
      v_eret = 1'b1;                            push(1'b1, ex(1,0,1,0,3'd0,3'd0), "R5");
      v_mret = 1'b1;                            push(1'b0, ex(1,0,1,0,3'd0,3'd0), "R5");
      // R6 correctly predicted branch
      v_ecbr = 1'b1; v_etkn = 1'b1;             push(1'b1, ex(0,0,0,0,3'd0,3'd0), "R6");
      @(negedge clk);
      @(posedge clk);

      // R3 / R4 load followed by consumer
      prog[0] = mk(0, NR, NR, NR, 4'd1, 0, 0, 0);
      prog[1] = mk(1, 4'd1, NR, 4'd2, NR, 0, 0, 0);
      run_prog(1'b1, 2, 1, 0, 1, 0, "R3");
      run_prog(1'b0, 2, 3, 0, 3, 0, "R4");
      // R2 / R4 back-to-back ALU dependence
      prog[0] = mk(0, NR, NR, 4'd1, NR, 0, 0, 0);
      prog[1] = mk(1, NR, 4'd1, 4'd2, NR, 0, 0, 0);
      run_prog(1'b1, 2, 0, 0, 0, 0, "R2");
      run_prog(1'b0, 2, 3, 0, 3, 0, "R4");
      // R4 one independent instruction in between
      prog[1] = mk(1, NR, NR, NR, NR, 0, 0, 0);
      prog[2] = mk(2, 4'd1, NR, 4'd2, NR, 0, 0, 0);
      run_prog(1'b0, 3, 2, 0, 2, 0, "R4");
      // R9 empty fields everywhere cost nothing
      for (int i = 0; i < 3; i++) prog[i] = mk(i, NR, NR, NR, NR, 0, 0, 0);
      run_prog(1'b0, 3, 0, 0, 0, 0, "R9");
      // R5 return
      prog[0] = mk(0, NR, NR, 4'd1, NR, 0, 0, 0);
      prog[1] = mk(1, NR, 4'd4, 4'd4, NR, 1, 0, 0);
      prog[2] = mk(2, NR, NR, 4'd2, NR, 0, 0, 0);
      run_prog(1'b1, 3, 3, 3, 0, 0, "R5");
      run_prog(1'b0, 3, 3, 3, 0, 0, "R5");
      // R6 mispredicted and correctly predicted branch
      prog[0] = mk(0, NR, NR, NR, NR, 0, 1, 0);
      prog[1] = mk(1, NR, NR, 4'd1, NR, 0, 0, 0);
      prog[2] = mk(2, 4'd1, NR, 4'd2, NR, 0, 0, 0);
      run_prog(1'b1, 3, 0, 1, 1, 1, "R6");
      run_prog(1'b0, 3, 3, 1, 4, 1, "R6");
      prog[0] = mk(0, NR, NR, NR, NR, 0, 1, 1);
      run_prog(1'b1, 3, 0, 0, 0, 0, "R6");
      // R10 pop then stack-pointer reader, then popped-register reader
      prog[0] = mk(0, 4'd4, NR, 4'd4, 4'd3, 0, 0, 0);
      prog[1] = mk(1, NR, 4'd4, 4'd5, NR, 0, 0, 0);
      run_prog(1'b1, 2, 0, 0, 0, 0, "R10");
      run_prog(1'b0, 2, 3, 0, 3, 0, "R10");
      prog[1] = mk(1, 4'd3, NR, 4'd5, NR, 0, 0, 0);
      run_prog(1'b1, 2, 1, 0, 1, 0, "R10");

      summary();
      $finish;
   end
endmodule